// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block decides when a temperature conversion runs and what the conversion leaves behind. Each conversion starts by latching the requested resolution. The block then waits a fixed number of clock cycles, and that number doubles for every extra bit of resolution. When the wait ends it asks a modelled converter for one raw signed sample over a request/valid handshake. It keeps only the data bits of the latched resolution and stores the value in a 16-bit two's complement result register. In the same cycle it raises a one-cycle done strobe, which downstream limit-comparison logic uses.

A shutdown input stops the conversion loop at the end of the conversion in progress. That conversion still finishes and its result is still stored. Clearing shutdown restarts continuous conversions. After reset one conversion always runs. If shutdown is already set at that point, this single conversion is the only one until shutdown is cleared. The parameter `UNIT_CYCLES` gives the number of clock cycles in one 25 ms unit, so a testbench can shrink every duration.

Top module: `temp_conv_seq`

## Requirements
- R1: While reset is high, `result` is 0, `done` is 0 and `smp_req` is 0. A conversion starts on the first clock edge after reset is released, whatever the state of `cfg_shutdown`.
- R2: A conversion lasts `UNIT_CYCLES << res` cycles, where `res` is the 2-bit resolution code: 00 is 9 bits, 01 is 10 bits, 10 is 11 bits and 11 is 12 bits. `smp_req` rises that many clock edges after the edge on which the conversion starts.
- R3: A stored result keeps sample bits 15 down to 7-`res` unchanged. Every bit below them is zero, so bits 3..0 are always zero. Bit 15 is the sign bit.
- R4: `done` is high for exactly one cycle, and that cycle is the one in which `result` takes its new value. `result` does not change in any other cycle.
- R5: If `cfg_shutdown` is high on the edge that accepts a sample, that sample is still stored. No further `smp_req` or `done` follows while shutdown stays high.
- R6: When the block is stopped and `cfg_shutdown` goes low, a new conversion starts on the next clock edge. From then on conversions run back to back, each one starting on the edge that stores the previous result.
- R7: If shutdown is high when reset is released, exactly one sample is requested and stored, and then the block stays stopped.
- R8: The resolution is latched on the edge that starts a conversion. A change of `cfg_res` during a conversion changes neither that conversion's duration nor its stored bits. It applies only to the next conversion.
- R9: `smp_req` stays high until `smp_valid` is seen with it, and drops on the next edge. A `smp_valid` without `smp_req` stores nothing and raises no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_res | input | 2 | Resolution code: 00 is 9 bits, 01 is 10, 10 is 11, 11 is 12 |
| cfg_shutdown | input | 1 | Stop after the current conversion when high |
| smp_req | output | 1 | Request for one sample from the converter |
| smp_valid | input | 1 | The converter presents a sample on `smp_data` |
| smp_data | input | 16 | Raw signed sample in result format |
| result | output | 16 | Stored result, two's complement |
| done | output | 1 | One-cycle strobe when `result` updates |

## Verification
`smp_req` is due exactly `UNIT_CYCLES << res` edges after a start edge. When a conversion is started by releasing reset or by clearing shutdown, that count begins one edge after the input change. `result` and `done` change on the same edge that sees `smp_valid` with `smp_req`.

The bench drives inputs one nanosecond after a rising edge and samples outputs on the falling edge. A cycle model, built from the requirements, advances on each rising edge and is compared with the outputs on every falling edge. Directed tasks count falling edges from a known stimulus to the expected event.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_CONV = 2'd1,
    ST_WAIT = 2'd2,
    ST_IDLE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/tconv_timer.sv
module tconv_timer #(
  parameter int UNIT_CYCLES = 5_000_000,
  parameter int RES_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] res,
  output logic             expired
);
  localparam longint MAX_DUR = longint'(UNIT_CYCLES) << ((1 << RES_W) - 1);
  localparam int     CNT_W   = $clog2(MAX_DUR + 1);

  logic [CNT_W-1:0] cnt;

  // Duration doubles per resolution step; counter runs down to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (CNT_W'(UNIT_CYCLES) << res) - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt == '0);

  // R2: once run out, the counter stays at zero until the next start
  p_expire_hold_r2: assert property (@(posedge clk) disable iff (rst)
    expired && !load |=> expired);
endmodule

// File: rtl/tconv_quant.sv
module tconv_quant #(
  parameter int DATA_W   = 16,
  parameter int RES_W    = 2,
  parameter int MIN_BITS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [RES_W-1:0]  res,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  localparam int MAX_EXTRA = (1 << RES_W) - 1;
  localparam int BASE_POS  = DATA_W - MIN_BITS;

  logic [DATA_W-1:0] keep;

  // Per-bit keep mask: always-kept top bits, always-zero bottom bits,
  // and a middle band selected by the resolution code.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i >= BASE_POS) begin : g_top
      assign keep[i] = 1'b1;
    end else if (i < BASE_POS - MAX_EXTRA) begin : g_low
      assign keep[i] = 1'b0;
    end else begin : g_mid
      assign keep[i] = (int'(res) >= BASE_POS - i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= capture;
      if (capture) begin
        result <= raw & keep;
      end
    end
  end

  // R4: strobe lasts one cycle
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: result only moves together with the strobe
  p_result_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
  // R3: nothing below the active resolution survives
  p_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> ((result & ~$past(keep)) == '0) && (result[3:0] == 4'h0));
endmodule

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
  import tconv_pkg::*;
#(
  parameter int RES_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RES_W-1:0] cfg_res,
  input  logic             cfg_shutdown,
  input  logic             smp_valid,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [RES_W-1:0] res_q,
  output logic             smp_req,
  output logic             capture
);
  seq_state_t state;
  logic       start;

  assign capture = (state == ST_WAIT) && smp_valid;

  // A conversion begins after reset, when leaving shutdown, or directly
  // after a stored result while shutdown is low.
  always_comb begin
    start = 1'b0;
    case (state)
      ST_BOOT: start = 1'b1;
      ST_IDLE: start = !cfg_shutdown;
      ST_WAIT: start = capture && !cfg_shutdown;
      default: start = 1'b0;
    endcase
  end

  assign tmr_load = start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_BOOT;
      res_q   <= '0;
      smp_req <= 1'b0;
    end else begin
      if (capture) begin
        smp_req <= 1'b0;
      end
      if (start) begin
        state <= ST_CONV;
        res_q <= cfg_res;
      end else begin
        case (state)
          ST_CONV: begin
            if (tmr_expired) begin
              state   <= ST_WAIT;
              smp_req <= 1'b1;
            end
          end
          ST_WAIT: begin
            if (capture) begin
              state <= ST_IDLE;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end

  // R9: request held until answered
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    smp_req && !smp_valid |=> smp_req);
  // R9: request withdrawn after the sample is taken
  p_req_drop_r9: assert property (@(posedge clk) disable iff (rst)
    smp_req && smp_valid |=> !smp_req);
  // R5: stopped block stays quiet while shutdown holds
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && cfg_shutdown |=> !smp_req && (state == ST_IDLE));
  // R8: latched resolution frozen during a conversion
  p_res_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV) |=> $stable(res_q));
  // R2: a request only follows a timed conversion
  p_req_after_conv_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(smp_req) |-> $past(state) == ST_CONV);
endmodule

// File: rtl/temp_conv_seq.sv
module temp_conv_seq #(
  parameter int UNIT_CYCLES = 5_000_000,
  parameter int DATA_W      = 16,
  parameter int RES_W       = 2,
  parameter int MIN_BITS    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RES_W-1:0]  cfg_res,
  input  logic              cfg_shutdown,
  output logic              smp_req,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic             tmr_load;
  logic             tmr_expired;
  logic             capture;
  logic [RES_W-1:0] res_q;

  tconv_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cfg_res      (cfg_res),
    .cfg_shutdown (cfg_shutdown),
    .smp_valid    (smp_valid),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .res_q        (res_q),
    .smp_req      (smp_req),
    .capture      (capture)
  );

  tconv_timer #(.UNIT_CYCLES(UNIT_CYCLES), .RES_W(RES_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .res     (cfg_res),
    .expired (tmr_expired)
  );

  tconv_quant #(.DATA_W(DATA_W), .RES_W(RES_W), .MIN_BITS(MIN_BITS)) u_quant (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .res     (res_q),
    .raw     (smp_data),
    .result  (result),
    .done    (done)
  );

  // R1: a conversion is always launched right after reset
  p_boot_start_r1: assert property (@(posedge clk)
    $fell(rst) |=> !smp_req && !done);
endmodule

// File: tb/temp_conv_seq_tb_top.sv
module temp_conv_seq_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int UNIT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_res = 2'd0;
  logic        cfg_shutdown = 1'b0;
  logic        smp_req;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic [15:0] result;
  logic        done;

  int n_total = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  temp_conv_seq #(.UNIT_CYCLES(UNIT)) dut_i (
    .clk(clk), .rst(rst), .cfg_res(cfg_res), .cfg_shutdown(cfg_shutdown),
    .smp_req(smp_req), .smp_valid(smp_valid), .smp_data(smp_data),
    .result(result), .done(done)
  );

  function automatic logic [15:0] quant(logic [15:0] raw, logic [1:0] r);
    return raw & (16'hFFFF << (7 - int'(r)));
  endfunction

  function automatic int dur(logic [1:0] r);
    return UNIT << r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- converter stub ----------------
  bit          fixed_mode = 1'b0;
  logic [15:0] fixed_data = '0;
  bit          spurious   = 1'b0;
  logic [15:0] stub_last  = '0;
  int          lat_cnt    = 0;
  int          lat_tgt    = 0;

  always @(negedge clk) begin
    if (rst) begin
      smp_valid <= 1'b0;
      lat_cnt = 0;
    end else if (smp_req) begin
      if (!smp_valid) begin
        if (lat_cnt >= lat_tgt) begin
          smp_data  <= fixed_mode ? fixed_data : 16'($urandom);
          smp_valid <= 1'b1;
          lat_cnt = 0;
          lat_tgt = $urandom_range(0, 3);
        end else begin
          lat_cnt++;
        end
      end
    end else begin
      smp_valid <= spurious;
      if (spurious) smp_data <= 16'($urandom);
    end
  end

  always @(posedge clk) if (smp_req && smp_valid) stub_last = smp_data;

  // ---------------- cycle model from the requirements ----------------
  int          m_st = 0;      // 0 boot, 1 converting, 2 waiting, 3 stopped
  int          m_left = 0;
  logic [1:0]  m_res = 0;
  logic [15:0] m_result = 0;
  bit          m_done = 0;

  always @(posedge clk) begin
    bit go;
    go = 1'b0;
    m_done = 1'b0;
    if (rst) begin
      m_st = 0; m_result = '0;
    end else begin
      case (m_st)
        0: go = 1'b1;
        1: if (m_left == 1) m_st = 2; else m_left--;
        2: if (smp_valid) begin
             m_result = quant(smp_data, m_res);
             m_done = 1'b1;
             if (!cfg_shutdown) go = 1'b1; else m_st = 3;
           end
        default: if (!cfg_shutdown) go = 1'b1;
      endcase
      if (go) begin
        m_res = cfg_res; m_left = dur(cfg_res); m_st = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(smp_req == (m_st == 2), "R2", "smp_req vs model", int'(smp_req), int'(m_st == 2));
      chk(done == m_done, "R4", "done vs model", int'(done), int'(m_done));
      chk(result == m_result, "R3", "result vs model", int'(result), int'(m_result));
    end
  end

  // ---------------- helpers ----------------
  task automatic wait_req(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!smp_req && n < 1000);
  endtask

  task automatic wait_done();
    int g;
    g = 0;
    do begin @(negedge clk); g++; end while (!done && g < 1000);
  endtask

  task automatic drive_reset(bit sd, logic [1:0] r);
    @(posedge clk); #1;
    rst = 1'b1; cfg_shutdown = sd; cfg_res = r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(result == 16'h0, "R1", "result in reset", int'(result), 0);
    chk(!done, "R1", "done in reset", int'(done), 0);
    chk(!smp_req, "R1", "smp_req in reset", int'(smp_req), 0);
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  // ---------------- main ----------------
  initial begin
    int n;
    int reqs;
    int dones;
    logic [15:0] held;
    logic [15:0] mask_exp [4];
    void'($urandom(32'd4242));
    mask_exp[0] = 16'hE680; mask_exp[1] = 16'hE6C0;
    mask_exp[2] = 16'hE6E0; mask_exp[3] = 16'hE6F0;

    // R1 / R2: power-up in run mode, 9-bit default duration
    drive_reset(1'b0, 2'd0);
    wait_req(n);
    chk(n == dur(0) + 2, "R1", "edges to first request", n, dur(0) + 2);

    // Random phase: resolution changes at random points (R8 via the model)
    for (int k = 0; k < 24; k++) begin
      repeat ($urandom_range(5, 40)) @(posedge clk);
      #1 cfg_res = 2'($urandom_range(0, 3));
    end

    // R3: directed truncation for every resolution code
    fixed_mode = 1'b1; fixed_data = 16'hE6FF;
    for (int r = 0; r < 4; r++) begin
      @(posedge clk); #1 cfg_res = 2'(r);
      wait_done();
      wait_done();
      chk(result == mask_exp[r], "R3", "truncated sample", int'(result), int'(mask_exp[r]));
    end
    fixed_data = 16'h7D0F;
    wait_done();
    chk(result == 16'h7D00, "R3", "positive 12-bit sample", int'(result), 16'h7D00);
    fixed_mode = 1'b0;

    // R8: change resolution right after a result, mid next conversion
    @(posedge clk); #1 cfg_res = 2'd2;
    wait_done();
    wait_done();
    cfg_res = 2'd0;
    wait_req(n);
    chk(n == dur(2), "R8", "duration keeps latched res", n, dur(2));
    wait_done();
    wait_req(n);
    chk(n == dur(0), "R8", "next duration uses new res", n, dur(0));

    // R5: shutdown during a conversion finishes it, then stops
    wait_done();
    @(posedge clk); #1 cfg_shutdown = 1'b1;
    wait_done();
    chk(result == quant(stub_last, 2'd0), "R5", "last result stored", int'(result),
        int'(quant(stub_last, 2'd0)));
    reqs = 0; dones = 0;
    repeat (120) begin @(negedge clk); reqs += int'(smp_req); dones += int'(done); end
    chk(reqs == 0, "R5", "requests while stopped", reqs, 0);
    chk(dones == 0, "R5", "strobes while stopped", dones, 0);

    // R9: valid without request is ignored
    held = result;
    @(posedge clk); #1 spurious = 1'b1;
    dones = 0;
    repeat (8) begin @(negedge clk); dones += int'(done); end
    @(posedge clk); #1 spurious = 1'b0;
    repeat (3) @(negedge clk);
    chk(result == held, "R9", "result after stray valid", int'(result), int'(held));
    chk(dones == 0, "R9", "strobes after stray valid", dones, 0);

    // R6: leaving shutdown restarts with the set resolution
    @(posedge clk); #1 cfg_res = 2'd2; cfg_shutdown = 1'b0;
    wait_req(n);
    chk(n == dur(2) + 2, "R6", "edges to request after wake", n, dur(2) + 2);
    wait_done();
    wait_req(n);
    chk(n == dur(2), "R6", "back-to-back conversion", n, dur(2));

    // R7: reset with shutdown set gives a single conversion
    drive_reset(1'b1, 2'd1);
    reqs = 0; dones = 0;
    begin
      bit prev;
      prev = 1'b0;
      repeat (300) begin
        @(negedge clk);
        if (smp_req && !prev) reqs++;
        prev = smp_req;
        dones += int'(done);
      end
    end
    chk(reqs == 1, "R7", "requests after shutdown power-up", reqs, 1);
    chk(dones == 1, "R7", "results after shutdown power-up", dones, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_total++; n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule